// File: doc/BRIEF.md
# Hardware breakpoint match unit

This unit watches the address stream of a processor core and raises a debug fault request when an access hits one of four programmable breakpoints. Each breakpoint has an address register and a slice of a shared control word that picks whether it is enabled, which access kinds it reacts to (instruction fetch, data write, or any data read or write) and how many bytes it covers (1, 2 or 4, aligned). A sticky status register records which breakpoints fired, until software clears the bits.

The core tells the unit when an instruction starts and when it retires. At instruction start the unit samples the core's resume flag. While that sampled flag is set, every match during the instruction is dropped: no fault and no status bit. At retire the unit tells the core what to do with the resume flag next. An ordinary instruction clears it. A flag-restoring instruction (interrupt return or flag pop) loads it from a value the core supplies. A control transfer that switches tasks leaves it alone.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset all breakpoint addresses, the control word and the status bits read as zero, and `fault`, `rf_wr` and `hit_status` are low.
- R2: Register indices 0 to 3 hold the four breakpoint addresses, index 6 is status (bits 3:0 valid), and index 7 is control, where bits 15:8 always read zero. Indices 4 and 5 read zero, and writes to them change no register. `reg_rdata` shows the register selected by `reg_idx` in the same cycle.
- R3: Breakpoint i enable field is control bits [2i+1:2i], and any nonzero value enables it. Its condition is bits [16+4i+1:16+4i], and its length is bits [18+4i+1:18+4i]. When condition 00 is set, only fetches (`acc_kind` 00) can match. A hit raises `fault` for exactly one cycle, on the clock edge after the access.
- R4: Condition 01 matches only writes (`acc_kind` 01). Condition 11 matches reads (`acc_kind` 10) and writes. Condition 10 never matches, and `acc_kind` 11 never matches.
- R5: Length 00 compares all address bits, 01 ignores address bit 0, and 10 or 11 ignore bits 1:0. The same bits are ignored in the stored address.
- R6: A breakpoint whose enable field is 00 never matches.
- R7: When several breakpoints hit in one access, all of their status bits set at once and a single fault pulse is issued.
- R8: A status bit sets on the edge where its fault is raised. It stays set until a write to index 6 replaces it. A hit in the same cycle as that write is ORed into the written value.
- R9: The resume flag `rf_in` is sampled when `insn_start` is high, and that same cycle already uses the new value. While the sampled value is 1, hits set no status bit and raise no fault.
- R10: A retire with class 00 or 11 pulses `rf_wr` one cycle later with `rf_wval` = 0.
- R11: A retire with class 01 (flag-restoring) pulses `rf_wr` one cycle later with `rf_wval` equal to `ret_rf_val`.
- R12: A retire with class 10 (task-switching transfer) produces no `rf_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Read data of the register selected by reg_idx |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | W | Access address |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read, 11 none |
| insn_start | input | 1 | First cycle of an instruction; samples rf_in |
| rf_in | input | 1 | Current resume flag of the core |
| ret_valid | input | 1 | Instruction retire strobe |
| ret_class | input | 2 | 00 plain, 01 flag-restoring, 10 task-switching, 11 plain |
| ret_rf_val | input | 1 | Resume flag value for a flag-restoring retire |
| fault | output | 1 | One-cycle debug fault request |
| hit_status | output | 4 | Sticky per-breakpoint hit bits |
| rf_wr | output | 1 | Resume flag update pulse |
| rf_wval | output | 1 | Value to write into the resume flag |

## Verification
A wrong breakpoint address or control field shows up one edge after the first access that should hit, or should not hit, that breakpoint. The symptom is a missing or spurious `fault` pulse and a wrong `hit_status` bit. Register contents are also visible at once through `reg_rdata`. A stale resume-flag sample only shows up on the next access that hits while that instruction is in progress, so the stimulus places hits right after `insn_start` and also several cycles later. A wrong retire decode is visible on `rf_wr` and `rf_wval` one cycle after the retire strobe.

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_idx,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         acc_valid,
  input  logic [W-1:0] acc_addr,
  input  logic [1:0]   acc_kind,
  input  logic         insn_start,
  input  logic         rf_in,
  input  logic         ret_valid,
  input  logic [1:0]   ret_class,
  input  logic         ret_rf_val,
  output logic         fault,
  output logic [3:0]   hit_status,
  output logic         rf_wr,
  output logic         rf_wval
);
  localparam int NBP = 4;
  localparam logic [31:0] CTRL_KEEP = 32'hFFFF_00FF;
  localparam logic [2:0] IDX_STAT = 3'd6;
  localparam logic [2:0] IDX_CTRL = 3'd7;

  logic [W-1:0]   bp_q [NBP];
  logic [31:0]    ctrl_q;
  logic [NBP-1:0] stat_q;
  logic           gate_q;
  logic [NBP-1:0] hit;
  logic           gate;
  logic [NBP-1:0] armed;

  for (genvar i = 0; i < NBP; i++) begin : g_bp
    logic [1:0]   en, cond, len;
    logic [W-1:0] keep;
    logic         kind_ok;
    assign en   = ctrl_q[2*i +: 2];
    assign cond = ctrl_q[16+4*i +: 2];
    assign len  = ctrl_q[18+4*i +: 2];
    assign keep = (len == 2'b00) ? '1 :
                  (len == 2'b01) ? {{(W-1){1'b1}}, 1'b0} : {{(W-2){1'b1}}, 2'b00};
    always_comb begin
      case (cond)
        2'b00:   kind_ok = (acc_kind == 2'b00);
        2'b01:   kind_ok = (acc_kind == 2'b01);
        2'b11:   kind_ok = (acc_kind == 2'b01) || (acc_kind == 2'b10);
        default: kind_ok = 1'b0;
      endcase
    end
    assign hit[i] = acc_valid && (en != 2'b00) && kind_ok &&
                    (((acc_addr ^ bp_q[i]) & keep) == '0);
  end

  assign gate  = insn_start ? rf_in : gate_q;
  assign armed = gate ? '0 : hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NBP; k++) bp_q[k] <= '0;
      ctrl_q  <= '0;
      stat_q  <= '0;
      gate_q  <= 1'b0;
      fault   <= 1'b0;
      rf_wr   <= 1'b0;
      rf_wval <= 1'b0;
    end else begin
      if (reg_we && !reg_idx[2]) bp_q[reg_idx[1:0]] <= reg_wdata;
      if (reg_we && reg_idx == IDX_CTRL) ctrl_q <= reg_wdata[31:0] & CTRL_KEEP;
      if (reg_we && reg_idx == IDX_STAT) stat_q <= reg_wdata[NBP-1:0] | armed;
      else                               stat_q <= stat_q | armed;
      if (insn_start) gate_q <= rf_in;
      fault   <= |armed;
      rf_wr   <= ret_valid && (ret_class != 2'b10);
      rf_wval <= ret_valid && (ret_class == 2'b01) && ret_rf_val;
    end
  end

  always_comb begin
    case (reg_idx)
      3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = bp_q[reg_idx[1:0]];
      IDX_STAT:               reg_rdata = {{(W-NBP){1'b0}}, stat_q};
      IDX_CTRL:               reg_rdata = {{(W-32){1'b0}}, ctrl_q};
      default:                reg_rdata = '0;
    endcase
  end

  assign hit_status = stat_q;
endmodule

// File: rtl/bkpt_match_unit_chk.sv
module bkpt_match_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [2:0]   reg_idx,
  input logic [W-1:0] reg_rdata,
  input logic         acc_valid,
  input logic         insn_start,
  input logic         rf_in,
  input logic         ret_valid,
  input logic [1:0]   ret_class,
  input logic         ret_rf_val,
  input logic         fault,
  input logic [3:0]   hit_status,
  input logic         rf_wr,
  input logic         rf_wval
);
  assert_fault_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(acc_valid));

  assert_fault_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> hit_status != 4'b0);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && reg_idx == 3'd6) |-> ((hit_status & $past(hit_status)) == $past(hit_status)));

  assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && insn_start && rf_in) |-> !fault);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == 3'd4 || reg_idx == 3'd5) |-> reg_rdata == '0);

  assert_plain_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret_valid && (ret_class == 2'b00 || ret_class == 2'b11)) |-> (rf_wr && !rf_wval));

  assert_load_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret_valid && ret_class == 2'b01) |-> (rf_wr && rf_wval == $past(ret_rf_val)));

  assert_task_switch_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret_valid && ret_class == 2'b10) |-> !rf_wr);

  assert_wr_needs_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> $past(ret_valid));
endmodule

bind bkpt_match_unit bkpt_match_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_rdata(reg_rdata),
  .acc_valid(acc_valid), .insn_start(insn_start), .rf_in(rf_in), .ret_valid(ret_valid),
  .ret_class(ret_class), .ret_rf_val(ret_rf_val), .fault(fault), .hit_status(hit_status),
  .rf_wr(rf_wr), .rf_wval(rf_wval)
);

// File: tb/bkpt_match_unit_tb.sv
module bkpt_match_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, acc_addr = 0;
  logic        acc_valid = 0, insn_start = 0, rf_in = 0, ret_valid = 0, ret_rf_val = 0;
  logic [1:0]  acc_kind = 0, ret_class = 0;
  logic        fault, rf_wr, rf_wval;
  logic [3:0]  hit_status;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  bkpt_match_unit u_dut (.*);

  always #10 clk = ~clk;

  logic [31:0] m_bp [4];
  logic [31:0] m_ctrl;
  logic [3:0]  m_stat;
  logic        m_gate, m_fault, m_rfwr, m_rfval;

  function automatic logic [3:0] m_hits();
    logic [3:0] h = 0;
    for (int b = 0; b < 4; b++) begin
      int unsigned en, cond, len, size;
      bit ok;
      en   = (m_ctrl >> (2*b)) & 3;
      cond = (m_ctrl >> (16 + 4*b)) & 3;
      len  = (m_ctrl >> (18 + 4*b)) & 3;
      size = (len == 0) ? 1 : (len == 1) ? 2 : 4;
      if (cond == 0)      ok = (acc_kind == 0);
      else if (cond == 1) ok = (acc_kind == 1);
      else if (cond == 3) ok = (acc_kind == 1 || acc_kind == 2);
      else                ok = 0;
      if (acc_valid && en != 0 && ok && (acc_addr / size) == (m_bp[b] / size)) h[b] = 1;
    end
    return h;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] idx);
    if (idx < 4)  return m_bp[idx[1:0]];
    if (idx == 6) return {28'd0, m_stat};
    if (idx == 7) return m_ctrl;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_bp[k] <= 0;
      m_ctrl <= 0; m_stat <= 0; m_gate <= 0; m_fault <= 0; m_rfwr <= 0; m_rfval <= 0;
    end else begin
      logic g;
      logic [3:0] h;
      g = insn_start ? rf_in : m_gate;
      h = g ? 4'b0 : m_hits();
      if (insn_start) m_gate <= rf_in;
      m_fault <= (h != 0);
      if (reg_we && reg_idx == 6) m_stat <= reg_wdata[3:0] | h;
      else m_stat <= m_stat | h;
      if (reg_we && reg_idx < 4) m_bp[reg_idx[1:0]] <= reg_wdata;
      if (reg_we && reg_idx == 7) m_ctrl <= reg_wdata & 32'hFFFF_00FF;
      m_rfwr  <= ret_valid && ret_class != 2;
      m_rfval <= ret_valid && ret_class == 1 && ret_rf_val;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("fault", {31'd0, fault}, {31'd0, m_fault});
      chk("hit_status", {28'd0, hit_status}, {28'd0, m_stat});
      chk("rf_wr", {31'd0, rf_wr}, {31'd0, m_rfwr});
      if (m_rfwr) chk("rf_wval", {31'd0, rf_wval}, {31'd0, m_rfval});
      chk("reg_rdata", reg_rdata, m_read(reg_idx));
    end
  end

  task automatic clear();
    reg_we = 0; acc_valid = 0; insn_start = 0; ret_valid = 0;
  endtask
  task automatic idle(input int n = 1);
    repeat (n) begin @(negedge clk); clear(); end
  endtask
  task automatic wr(input logic [2:0] idx, input logic [31:0] v);
    @(negedge clk); clear(); reg_we = 1; reg_idx = idx; reg_wdata = v;
  endtask
  task automatic rd(input logic [2:0] idx);
    @(negedge clk); clear(); reg_idx = idx;
  endtask
  task automatic acc(input logic [1:0] k, input logic [31:0] a,
                     input logic st = 0, input logic rf = 0);
    @(negedge clk); clear(); acc_valid = 1; acc_kind = k; acc_addr = a;
    insn_start = st; rf_in = rf;
  endtask
  task automatic retire(input logic [1:0] c, input logic v);
    @(negedge clk); clear(); ret_valid = 1; ret_class = c; ret_rf_val = v;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  localparam logic [31:0] CTRL_A = 32'h27D0_0079;

  initial begin
    cur_req = "R1";
    repeat (2) @(posedge clk);
    #5;
    chk("reset fault", {31'd0, fault}, 0);
    chk("reset status", {28'd0, hit_status}, 0);
    chk("reset rf_wr", {31'd0, rf_wr}, 0);
    chk("reset rdata", reg_rdata, 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 8; i++) rd(3'(i));

    cur_req = "R2";
    wr(0, 32'h0000_1000); wr(1, 32'h0000_2004); wr(2, 32'h0000_3002); wr(3, 32'h0000_4000);
    wr(7, CTRL_A | 32'h0000_FF00);
    for (int i = 0; i < 8; i++) rd(3'(i));
    wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) rd(3'(i));

    cur_req = "R3";
    acc(0, 32'h1000); idle(2);
    acc(0, 32'h1001); acc(2, 32'h1000); acc(1, 32'h1000); idle(2);
    wr(6, 0);

    cur_req = "R4";
    acc(1, 32'h2004); acc(2, 32'h2004); acc(0, 32'h2004); idle();
    acc(2, 32'h3002); acc(1, 32'h3003); acc(3, 32'h3002);
    acc(0, 32'h4000); acc(1, 32'h4000); acc(2, 32'h4000); idle(2);
    wr(6, 0);

    cur_req = "R5";
    acc(1, 32'h2007); acc(1, 32'h2008); acc(1, 32'h2003); idle();
    wr(6, 0);
    acc(2, 32'h3003); acc(2, 32'h3004); acc(2, 32'h3001); idle();
    wr(6, 0);

    cur_req = "R6";
    wr(7, CTRL_A & ~32'h3);
    acc(0, 32'h1000); idle(2);
    wr(7, CTRL_A);

    cur_req = "R7";
    wr(3, 32'h0000_3002);
    wr(7, (CTRL_A & 32'h0FFF_FFFF) | 32'h7000_0000);
    acc(1, 32'h3002); idle(2);

    cur_req = "R8";
    idle(3); rd(6);
    wr(6, 4'b0100); rd(6);
    acc(0, 32'h1000);
    wr(6, 0); idle();
    acc(0, 32'h1000); wr(6, 4'b0010); idle(); wr(6, 0);
    @(negedge clk); clear(); reg_we = 1; reg_idx = 6; reg_wdata = 0;
    acc_valid = 1; acc_kind = 0; acc_addr = 32'h1000;
    idle(2); wr(6, 0);

    cur_req = "R9";
    acc(0, 32'h1000, 1, 1); idle(); acc(0, 32'h1000); acc(1, 32'h2004);
    acc(0, 32'h1000, 1, 0); idle();
    acc(0, 32'h1000, 0, 1); idle();
    @(negedge clk); clear(); insn_start = 1; rf_in = 1;
    acc(1, 32'h3002);
    acc(1, 32'h3002, 1, 0); idle(2);
    wr(6, 0);

    cur_req = "R10";
    retire(0, 1); retire(3, 1); idle(2);
    cur_req = "R11";
    retire(1, 1); retire(1, 0); idle(2);
    cur_req = "R12";
    retire(2, 1); idle(2);

    cur_req = "R3";
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] base;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: base = 32'h1000; 1: base = 32'h2004; 2: base = 32'h3000; default: base = 32'h4000;
      endcase
      if (op < 6) acc(2'($urandom_range(0, 3)), base + $urandom_range(0, 7),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
      else if (op == 6) retire(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      else if (op == 7) wr(6, $urandom_range(0, 15));
      else if (op == 8) wr(7, $urandom());
      else rd(3'($urandom_range(0, 7)));
    end
    idle(3);
    finish_sim();
  end
endmodule